// File: doc/BRIEF.md
# Adaptive Clock Frequency Controller

This block closes a control loop between timing-error events and a tunable on-chip clock source. It receives an error pulse that is already synchronized to its clock. From that pulse it drives two outputs: a coarse tap select for a ring oscillator with 31 taps, and a fine trim code for a switched-capacitor adjustment network. A single error lowers the frequency at once. A long stretch without errors raises it by one step. The clock therefore settles close to the point where errors first appear.

The frequency setting is held as one index. The upper bits of the index form the tap select and the lower bits form the trim code, so a trim overflow carries into the tap select and a trim underflow borrows from it. Configuration inputs set the lower and upper bounds, the step size, the length of the error-free window and a guard interval after each change. A mode bit turns adaptation off and applies a fixed setting.

Top module: `freq_adapt_ctrl`

## Requirements
- R1: While reset is asserted the setting index is 256, so tap_sel reads 16 and trim_code reads 0. The quiet counter and the guard counter are both zero.
- R2: tap_sel carries bits [8:4] of the 9-bit index and trim_code carries bits [3:0]. A higher index means a faster clock. Stepping from 255 to 256 gives tap 16 and trim 0, and stepping from 256 to 255 gives tap 15 and trim 15.
- R3: An accepted error lowers the index by cfg_step at that clock edge, and the new value is visible on the outputs after that edge. An error is accepted when adaptation is on and the guard counter is zero. An accepted error also clears the quiet counter.
- R4: When cfg_window consecutive edges pass without an accepted error, the index rises by cfg_step on the last of those edges and counting starts again from zero. A window of 0 or 1 steps the index up on every quiet edge.
- R5: The index saturates at cfg_min when stepping down. When stepping up it saturates at the smaller of cfg_max and 495 (tap 30, trim 15). It never wraps, and a step of 0 leaves it unchanged.
- R6: Every change of the index made by adaptation loads the guard counter with cfg_guard. Errors on the next cfg_guard edges are ignored: they do not step the index and they do not clear the quiet counter.
- R7: If an accepted error and the end of the quiet window fall on the same edge, the error wins and the index steps down.
- R8: While cfg_fixed is 1, the index takes cfg_fixed_set, limited to 495, one edge later, and errors are ignored. While it is held, both counters are cleared. Adaptation resumes from that value once cfg_fixed returns to 0.
- R9: tap_sel never exceeds 30.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| err_pulse | input | 1 | Synchronized timing-error event, one per cycle at most |
| cfg_fixed | input | 1 | 1 = hold the fixed setting, 0 = adapt |
| cfg_fixed_set | input | 9 | Index applied in fixed mode |
| cfg_min | input | 9 | Lowest index allowed by adaptation |
| cfg_max | input | 9 | Highest index allowed by adaptation (capped at 495) |
| cfg_step | input | 9 | Index change per step |
| cfg_window | input | 16 | Error-free edges needed for a speedup |
| cfg_guard | input | 8 | Edges after a change during which errors are ignored |
| tap_sel | output | 5 | Ring-oscillator tap select |
| trim_code | output | 4 | Switched-capacitor trim code |

## Verification
The hardest case to reach from the ports is an error that arrives during the guard interval. Such an error must leave the index alone, and it must also leave the quiet counter running. No output shows the counter directly. The bench makes it visible through timing: it sets the quiet window only a few edges longer than the guard interval, then holds the error pulse high through the whole guard interval. The speedup must then come on the edge that counts from the accepted error. It must not come one full window after the ignored errors. A vector table loads known starting points through fixed mode and covers carry and borrow across the tap boundary, both saturation limits, the cap at 495 and a zero step.

// File: rtl/freq_adapt_ctrl.sv
module freq_adapt_ctrl #(
  parameter int TAPS     = 31,
  parameter int TRIM_W   = 4,
  parameter int CNT_W    = 16,
  parameter int GUARD_W  = 8,
  parameter int INIT_IDX = 256,
  localparam int TAP_W   = $clog2(TAPS),
  localparam int IDX_W   = TAP_W + TRIM_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               err_pulse,
  input  logic               cfg_fixed,
  input  logic [IDX_W-1:0]   cfg_fixed_set,
  input  logic [IDX_W-1:0]   cfg_min,
  input  logic [IDX_W-1:0]   cfg_max,
  input  logic [IDX_W-1:0]   cfg_step,
  input  logic [CNT_W-1:0]   cfg_window,
  input  logic [GUARD_W-1:0] cfg_guard,
  output logic [TAP_W-1:0]   tap_sel,
  output logic [TRIM_W-1:0]  trim_code
);

  localparam logic [IDX_W-1:0] MAX_IDX = IDX_W'(TAPS * (2 ** TRIM_W) - 1);
  localparam logic [TAP_W-1:0] MAX_TAP = TAP_W'(TAPS - 1);

  logic [IDX_W-1:0]   idx, nxt;
  logic [CNT_W-1:0]   quiet;
  logic [GUARD_W-1:0] guard_cnt;

  wire [IDX_W-1:0] hi      = (cfg_max > MAX_IDX) ? MAX_IDX : cfg_max;
  wire [IDX_W-1:0] fixed_c = (cfg_fixed_set > MAX_IDX) ? MAX_IDX : cfg_fixed_set;
  wire [IDX_W:0]   sum     = {1'b0, idx} + {1'b0, cfg_step};
  wire [IDX_W:0]   diff    = {1'b0, idx} - {1'b0, cfg_step};
  wire [IDX_W-1:0] up_v    = (sum > {1'b0, hi}) ? hi : sum[IDX_W-1:0];
  wire [IDX_W-1:0] dn_v    = (diff[IDX_W] || diff[IDX_W-1:0] < cfg_min) ? cfg_min : diff[IDX_W-1:0];

  wire err_acc    = err_pulse && (guard_cnt == '0) && !cfg_fixed;
  wire quiet_done = ({1'b0, quiet} + 1'b1) >= {1'b0, cfg_window};

  always_comb begin
    if (cfg_fixed)       nxt = fixed_c;
    else if (err_acc)    nxt = dn_v;
    else if (quiet_done) nxt = up_v;
    else                 nxt = idx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx       <= IDX_W'(INIT_IDX);
      quiet     <= '0;
      guard_cnt <= '0;
    end else begin
      idx <= nxt;
      if (cfg_fixed || err_acc || quiet_done) quiet <= '0;
      else                                    quiet <= quiet + 1'b1;
      if (cfg_fixed)             guard_cnt <= '0;
      else if (nxt != idx)       guard_cnt <= cfg_guard;
      else if (guard_cnt != '0)  guard_cnt <= guard_cnt - 1'b1;
    end
  end

  assign tap_sel   = idx[IDX_W-1:TRIM_W];
  assign trim_code = idx[TRIM_W-1:0];

  // R3
  err_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_pulse && guard_cnt == '0 && !cfg_fixed && idx >= cfg_min) |=> (idx <= $past(idx)));

  // R5
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_pulse && guard_cnt == '0 && !cfg_fixed && idx >= cfg_min) |=> (idx >= $past(cfg_min)));

  // R6
  guard_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_fixed && guard_cnt != '0 && !quiet_done) |=> $stable(idx));

  // R8
  fixed_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_fixed && cfg_fixed_set <= MAX_IDX) |=> (idx == $past(cfg_fixed_set)));

  // R9
  tap_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tap_sel <= MAX_TAP);

endmodule

// File: tb/freq_adapt_ctrl_test.sv
module freq_adapt_ctrl_test;
  logic clk = 0;
  logic rst_n = 0;
  logic err_pulse = 0, cfg_fixed = 0;
  logic [8:0] cfg_fixed_set = 0, cfg_min = 0, cfg_max = 9'd495, cfg_step = 9'd1;
  logic [15:0] cfg_window = 16'd1024;
  logic [7:0] cfg_guard = 8'd4;
  logic [4:0] tap_sel;
  logic [3:0] trim_code;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  freq_adapt_ctrl uut (
    .clk(clk), .rst_n(rst_n), .err_pulse(err_pulse), .cfg_fixed(cfg_fixed),
    .cfg_fixed_set(cfg_fixed_set), .cfg_min(cfg_min), .cfg_max(cfg_max),
    .cfg_step(cfg_step), .cfg_window(cfg_window), .cfg_guard(cfg_guard),
    .tap_sel(tap_sel), .trim_code(trim_code)
  );

  // start, step, lo, hi, dir (0 = error, 1 = window up), expected
  localparam logic [45:0] VEC [0:9] = '{
    {9'd256, 9'd1,  9'd0,  9'd495, 1'b0, 9'd255},
    {9'd255, 9'd1,  9'd0,  9'd495, 1'b1, 9'd256},
    {9'd100, 9'd16, 9'd0,  9'd495, 1'b0, 9'd84},
    {9'd100, 9'd16, 9'd90, 9'd495, 1'b0, 9'd90},
    {9'd490, 9'd8,  9'd0,  9'd495, 1'b1, 9'd495},
    {9'd490, 9'd8,  9'd0,  9'd511, 1'b1, 9'd495},
    {9'd300, 9'd20, 9'd0,  9'd310, 1'b1, 9'd310},
    {9'd5,   9'd10, 9'd0,  9'd495, 1'b0, 9'd0},
    {9'd200, 9'd0,  9'd0,  9'd495, 1'b0, 9'd200},
    {9'd47,  9'd33, 9'd0,  9'd495, 1'b1, 9'd80}
  };

  function automatic logic [8:0] cur();
    return {tap_sel, trim_code};
  endfunction

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, logic [8:0] got, logic [8:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic load(logic [8:0] start, logic [8:0] st, logic [8:0] lo,
                      logic [8:0] hi_b, logic [15:0] win, logic [7:0] grd);
    cfg_fixed = 1; cfg_fixed_set = start; cfg_step = st; cfg_min = lo;
    cfg_max = hi_b; cfg_window = win; cfg_guard = grd;
    tick(1);
    cfg_fixed = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    tick(3);
    chk("R1 reset tap/trim", cur(), 9'd256);
    chk("R1 reset tap field", {4'd0, tap_sel}, 9'd16);
    rst_n = 1;
    tick(1023);
    chk("R4 default window not yet", cur(), 9'd256);
    tick(1);
    chk("R4 default window step up", cur(), 9'd257);
    cfg_window = 16'd8;
    tick(7);
    chk("R4 counter restart hold", cur(), 9'd257);
    tick(1);
    chk("R4 counter restart step", cur(), 9'd258);

    foreach (VEC[i]) begin
      load(VEC[i][45:37], VEC[i][36:28], VEC[i][27:19], VEC[i][18:10],
           VEC[i][9] ? 16'd2 : 16'd1000, 8'd0);
      if (VEC[i][9]) tick(2);
      else begin
        err_pulse = 1; tick(1); err_pulse = 0;
      end
      chk($sformatf("R2/R5 vector %0d", i), cur(), VEC[i][8:0]);
      chk($sformatf("R9 tap range vector %0d", i), {4'd0, tap_sel} <= 9'd30 ? 9'd1 : 9'd0, 9'd1);
    end

    // R3: error clears quiet counter
    load(9'd150, 9'd1, 9'd0, 9'd495, 16'd8, 8'd0);
    tick(5);
    err_pulse = 1; tick(1); err_pulse = 0;
    chk("R3 error step down", cur(), 9'd149);
    tick(7);
    chk("R3 counter cleared hold", cur(), 9'd149);
    tick(1);
    chk("R3 counter cleared step", cur(), 9'd150);

    // R6: guard ignores errors without clearing counter
    load(9'd220, 9'd1, 9'd0, 9'd495, 16'd5, 8'd3);
    err_pulse = 1; tick(1);
    chk("R6 first error accepted", cur(), 9'd219);
    tick(3); err_pulse = 0;
    chk("R6 guarded errors ignored", cur(), 9'd219);
    tick(1);
    chk("R6 window still running", cur(), 9'd219);
    tick(1);
    chk("R6 speedup from accepted error", cur(), 9'd220);

    // R7: error wins over window end
    load(9'd300, 9'd4, 9'd0, 9'd495, 16'd2, 8'd0);
    tick(1);
    err_pulse = 1; tick(1); err_pulse = 0;
    chk("R7 error beats speedup", cur(), 9'd296);

    // R4: window of zero steps every edge
    load(9'd10, 9'd1, 9'd0, 9'd495, 16'd0, 8'd0);
    tick(3);
    chk("R4 zero window", cur(), 9'd13);

    // R8: fixed mode
    cfg_fixed = 1; cfg_fixed_set = 9'd77; err_pulse = 1;
    tick(3);
    chk("R8 fixed ignores errors", cur(), 9'd77);
    cfg_fixed_set = 9'd511;
    tick(1);
    chk("R8 fixed clamp", cur(), 9'd495);
    err_pulse = 0; cfg_fixed_set = 9'd77; tick(1);
    cfg_fixed = 0; cfg_window = 16'd3; cfg_step = 9'd1;
    tick(2);
    chk("R8 resume hold", cur(), 9'd77);
    tick(1);
    chk("R8 resume step", cur(), 9'd78);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule